// File: doc/BRIEF.md
# Timer-Clocked Serial Shift Port

This block is the serial byte channel of a peripheral I/O controller. One 8-bit shifter serves both directions. A mode input selects the direction.

In receive mode, a remote device drives the serial clock pin. The port takes in one data bit on each rising edge of that clock, most significant bit first. After the eighth edge it moves the assembled byte into a readable data register.

In transmit mode, a register write loads the shifter and starts the byte. The port then builds its own serial clock from the underflow strobes of an interval timer that lives outside this block. The clock and data pins have separate output enables. Those enables are asserted only while a byte is being sent, so several devices can share the same two wires.

Each finished byte, in either direction, sets a completion flag. The flag stays set until it is acknowledged.

Top module: `serial_shift_port`

## Requirements
- R1: After reset, both output enables are low, `sclk_out` is high (the idle level), `done_flag` is 0 and `rd_data` is 0.
- R2: With `dir_out`=1 (transmit) and no byte in progress, a pulse on `wr_en` loads `wr_data` into the shifter. `sclk_oe` and `sdat_oe` go high on the next cycle, and `sdat_out` presents bit 7 first.
- R3: While transmitting, each `tmr_uflow` pulse toggles `sclk_out`. The clock starts high and falls on the first pulse. A byte takes exactly 16 pulses. After the 16th pulse `sclk_out` is high, both enables are low and `done_flag` is set.
- R4: While transmitting, `sdat_out` changes only on a cycle in which `sclk_out` falls. The transmitted bits, sampled on the rising edges of `sclk_out`, equal the written byte, MSB first.
- R5: With `dir_out`=0 (receive), `sdat_in` is sampled on each rising edge of `sclk_in`, MSB first. Both pins pass through a two-stage synchronizer. On the 8th edge the byte is copied to `rd_data` and `done_flag` is set. A bit period of 4 clocks (2 high, 2 low) is accepted.
- R6: `done_flag` stays set until a `done_ack` pulse clears it. If a byte completes in the same cycle as `done_ack`, the flag stays set.
- R7: The following have no effect: `wr_en` in receive mode, `wr_en` while a byte is being transmitted, and `tmr_uflow` when not transmitting.
- R8: The lines are released whenever no byte is in transmission. Dropping `dir_out` during a byte aborts it: both enables are low and `sclk_out` is high one cycle later, and no completion is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_out | input | 1 | Mode: 1 transmit, 0 receive |
| wr_en | input | 1 | Register write strobe for the data byte |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Last received byte |
| tmr_uflow | input | 1 | One-cycle underflow strobe from the interval timer |
| sclk_in | input | 1 | Serial clock pin, input side |
| sclk_out | output | 1 | Serial clock pin, output side |
| sclk_oe | output | 1 | Output enable of the serial clock pin |
| sdat_in | input | 1 | Serial data pin, input side |
| sdat_out | output | 1 | Serial data pin, output side |
| sdat_oe | output | 1 | Output enable of the serial data pin |
| done_flag | output | 1 | Byte-complete flag |
| done_ack | input | 1 | Clears `done_flag` |

## Verification
A byte completion and a flag acknowledge can land on the same clock edge. The set path has to win that race, or the completion would be lost.

The bench first leaves the flag set from one received byte. It then times a one-cycle `done_ack` so that the acknowledge is sampled on exactly the edge where the synchronized eighth clock rise of the next byte completes. Counting the synchronizer stages, that is the third edge after the bench raises `sclk_in`.

The check then requires the flag to still be set, with `rd_data` holding the new byte. A later lone acknowledge must clear the flag.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic {
    SSP_RX = 1'b0,
    SSP_TX = 1'b1
  } ssp_dir_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } ssp_edge_t;
endpackage

// File: rtl/ssp_rst_sync.sv
module ssp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ssp_txclk.sv
module ssp_txclk
  import ssp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      active,
  input  logic      uflow,
  output logic      sclk,
  output ssp_edge_t evt
);
  logic sclk_q;
  logic sclk_d;

  always_comb begin
    evt.rise = active & uflow & ~sclk_q;
    evt.fall = active & uflow & sclk_q;
    if (!active)    sclk_d = 1'b1;
    else if (uflow) sclk_d = ~sclk_q;
    else            sclk_d = sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b1;
    else        sclk_q <= sclk_d;
  end

  assign sclk = sclk_q;
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         shift_in,
  input  logic         cnt_en,
  input  logic         cnt_clr,
  output logic [W-1:0] data,
  output logic         cnt_last,
  output logic         cnt_zero
);
  localparam int CNT_W = (W > 2) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     data_q, data_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)          data_d = load_val;
    else if (shift_en) data_d = {data_q[W-2:0], shift_in};
    else               data_d = data_q;

    if (cnt_clr)     cnt_d = '0;
    else if (cnt_en) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      data_q <= data_d;
      cnt_q  <= cnt_d;
    end
  end

  assign data     = data_q;
  assign cnt_last = (cnt_q == LAST);
  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/serial_shift_port.sv
module serial_shift_port
  import ssp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_out,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tmr_uflow,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sdat_in,
  output logic              sdat_out,
  output logic              sdat_oe,
  output logic              done_flag,
  input  logic              done_ack
);
  logic        rst_n_q;
  logic        sclk_s, sdat_s;
  ssp_dir_e    mode;
  ssp_edge_t   tx_evt;
  logic [DATA_W-1:0] sh_data;
  logic        cnt_last, cnt_zero;

  logic        busy_q, busy_d;
  ssp_dir_e    mode_q;
  logic        sclk_prev_q;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic        flag_q, flag_d;

  logic        load, rx_rise, rx_done, tx_done, sh_en, cnt_en, cnt_clr;

  assign mode = ssp_dir_e'(dir_out);

  ssp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_q)
  );

  ssp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n_q), .d(sclk_in), .q(sclk_s)
  );

  ssp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdat_sync (
    .clk(clk), .rst_n(rst_n_q), .d(sdat_in), .q(sdat_s)
  );

  ssp_txclk u_txclk (
    .clk(clk), .rst_n(rst_n_q),
    .active(busy_q && mode == SSP_TX),
    .uflow(tmr_uflow),
    .sclk(sclk_out), .evt(tx_evt)
  );

  ssp_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n_q),
    .load(load), .load_val(wr_data),
    .shift_en(sh_en), .shift_in(sdat_s),
    .cnt_en(cnt_en), .cnt_clr(cnt_clr),
    .data(sh_data), .cnt_last(cnt_last), .cnt_zero(cnt_zero)
  );

  always_comb begin
    load    = (mode == SSP_TX) && wr_en && !busy_q;
    rx_rise = (mode == SSP_RX) && sclk_s && !sclk_prev_q;
    rx_done = rx_rise && cnt_last;
    tx_done = busy_q && tx_evt.rise && cnt_last;
    sh_en   = (tx_evt.fall && !cnt_zero) || rx_rise;
    cnt_en  = tx_evt.rise || rx_rise;
    cnt_clr = load || (mode != mode_q);

    if (mode != SSP_TX) busy_d = 1'b0;
    else if (load)      busy_d = 1'b1;
    else if (tx_done)   busy_d = 1'b0;
    else                busy_d = busy_q;

    rd_d = rx_done ? {sh_data[DATA_W-2:0], sdat_s} : rd_q;

    if (rx_done || tx_done) flag_d = 1'b1;
    else if (done_ack)      flag_d = 1'b0;
    else                    flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      busy_q      <= 1'b0;
      mode_q      <= SSP_RX;
      sclk_prev_q <= 1'b1;
      rd_q        <= '0;
      flag_q      <= 1'b0;
    end else begin
      busy_q      <= busy_d;
      mode_q      <= mode;
      sclk_prev_q <= sclk_s;
      rd_q        <= rd_d;
      flag_q      <= flag_d;
    end
  end

  assign rd_data   = rd_q;
  assign sclk_oe   = busy_q;
  assign sdat_oe   = busy_q;
  assign sdat_out  = sh_data[DATA_W-1];
  assign done_flag = flag_q;
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk (
  input logic clk,
  input logic rst_n,
  input logic dir_out,
  input logic tmr_uflow,
  input logic sclk_out,
  input logic sclk_oe,
  input logic sdat_out,
  input logic done_flag,
  input logic done_ack
);
  // R1
  idle_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_oe |-> sclk_out);

  // R3
  clock_moves_on_uflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_oe && dir_out && !tmr_uflow) |=> $stable(sclk_out));

  // R4
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_oe && $past(sclk_oe) && !$fell(sclk_out)) |-> $stable(sdat_out));

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !done_ack) |=> done_flag);

  // R8
  release_on_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_out |=> !sclk_oe);
endmodule

bind serial_shift_port ssp_port_chk u_port_chk (
  .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .tmr_uflow(tmr_uflow),
  .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdat_out(sdat_out),
  .done_flag(done_flag), .done_ack(done_ack)
);

// File: tb/tb_serial_shift_port.sv
module tb_serial_shift_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_out = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tmr_uflow = 1'b0;
  logic       sclk_in = 1'b1;
  logic       sclk_out, sclk_oe;
  logic       sdat_in = 1'b0;
  logic       sdat_out, sdat_oe;
  logic       done_flag;
  logic       done_ack = 1'b0;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_q[$];
  logic [7:0] cap = 8'h00;
  logic       prev_sclk = 1'b1;
  logic       prev_oe = 1'b0;
  logic       prev_flag = 1'b0;

  always #2 clk = ~clk;

  serial_shift_port dut (
    .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tmr_uflow(tmr_uflow),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .sdat_in(sdat_in), .sdat_out(sdat_out), .sdat_oe(sdat_oe),
    .done_flag(done_flag), .done_ack(done_ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: captures the transmitted line and pops the scoreboard on each flag rise
  always @(negedge clk) begin
    logic [7:0] nc;
    logic [7:0] ev;
    nc = cap;
    if (rst_n && sclk_out && !prev_sclk && prev_oe) nc = {cap[6:0], sdat_out};
    if (rst_n && done_flag && !prev_flag) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected completion", 1, 0);
      end else begin
        ev = exp_q.pop_front();
        if (dir_out) chk(nc == ev, "R4 transmitted byte", nc, ev);
        else         chk(rd_data == ev, "R5 received byte", rd_data, ev);
      end
    end
    cap       = nc;
    prev_sclk = sclk_out;
    prev_oe   = sclk_oe;
    prev_flag = done_flag;
  end

  task automatic ack_flag();
    @(negedge clk) done_ack = 1'b1;
    @(negedge clk) done_ack = 1'b0;
    chk(done_flag == 1'b0, "R6 ack clears flag", done_flag, 0);
  endtask

  task automatic send_tx(input logic [7:0] b, input int gap, input bit poke);
    exp_q.push_back(b);
    @(negedge clk) begin wr_en = 1'b1; wr_data = b; cap = 8'h00; end
    @(negedge clk) wr_en = 1'b0;
    chk(sclk_oe && sdat_oe, "R2 enables after write", {sclk_oe, sdat_oe}, 3);
    chk(sdat_out == b[7], "R2 MSB first on line", sdat_out, b[7]);
    for (int i = 0; i < 16; i++) begin
      repeat (gap) @(negedge clk);
      if (i == 15) chk(sclk_oe == 1'b1, "R3 busy before 16th underflow", sclk_oe, 1);
      tmr_uflow = 1'b1;
      if (poke && i == 5) begin wr_en = 1'b1; wr_data = ~b; end
      @(negedge clk);
      tmr_uflow = 1'b0;
      wr_en = 1'b0;
    end
    chk(!sclk_oe && !sdat_oe && sclk_out, "R3 done after 16 underflows",
        {sclk_oe, sdat_oe, sclk_out}, 1);
    chk(done_flag == 1'b1, "R3 flag after transmit", done_flag, 1);
    ack_flag();
  endtask

  task automatic send_rx(input logic [7:0] b, input int half, input bit ack_hit);
    if (!ack_hit) exp_q.push_back(b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) begin sclk_in = 1'b0; sdat_in = b[i]; end
      repeat (half - 1) @(negedge clk);
      @(negedge clk) sclk_in = 1'b1;
      if (i == 0 && ack_hit) begin
        @(negedge clk);
        @(negedge clk) done_ack = 1'b1;
        @(negedge clk) done_ack = 1'b0;
      end else begin
        repeat (half - 1) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!sclk_oe && !sdat_oe, "R1 enables low", {sclk_oe, sdat_oe}, 0);
    chk(sclk_out == 1'b1, "R1 idle clock high", sclk_out, 1);
    chk(done_flag == 1'b0 && rd_data == 8'h00, "R1 flag and data", {done_flag, rd_data}, 0);

    // R7 underflow and write in receive mode
    @(negedge clk) begin tmr_uflow = 1'b1; wr_en = 1'b1; wr_data = 8'h6E; end
    @(negedge clk) begin tmr_uflow = 1'b0; wr_en = 1'b0; end
    repeat (2) @(negedge clk);
    chk(!sclk_oe && !sdat_oe && sclk_out, "R7 rx-mode write/underflow ignored",
        {sclk_oe, sdat_oe, sclk_out}, 1);
    chk(done_flag == 1'b0 && rd_data == 8'h00, "R7 rx-mode write no data", rd_data, 0);

    // transmit
    dir_out = 1'b1;
    repeat (2) @(negedge clk);
    send_tx(8'hA5, 1, 1'b0);
    send_tx(8'h3C, 3, 1'b0);
    send_tx(8'h80, 0, 1'b1);   // R7 write while busy ignored
    send_tx(8'h01, 2, 1'b0);

    // R8 abort
    @(negedge clk) begin wr_en = 1'b1; wr_data = 8'h99; end
    @(negedge clk) wr_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) tmr_uflow = 1'b1;
      @(negedge clk) tmr_uflow = 1'b0;
    end
    dir_out = 1'b0;
    @(negedge clk);
    chk(!sclk_oe && !sdat_oe && sclk_out, "R8 abort releases lines",
        {sclk_oe, sdat_oe, sclk_out}, 1);
    repeat (6) @(negedge clk);
    chk(done_flag == 1'b0, "R8 abort flags nothing", done_flag, 0);

    // receive
    send_rx(8'h5A, 2, 1'b0);
    repeat (5) @(negedge clk);
    chk(done_flag == 1'b1, "R6 flag holds without ack", done_flag, 1);
    send_rx(8'hC3, 2, 1'b1);
    chk(done_flag == 1'b1, "R6 completion wins over same-cycle ack", done_flag, 1);
    chk(rd_data == 8'hC3, "R5 byte with same-cycle ack", rd_data, 8'hC3);
    ack_flag();
    send_rx(8'hFF, 5, 1'b0);
    ack_flag();
    send_rx(8'h00, 3, 1'b0);
    ack_flag();
    send_rx(8'h96, 2, 1'b0);

    // R7 write in receive mode leaves data and lines alone
    @(negedge clk) begin wr_en = 1'b1; wr_data = 8'h11; end
    @(negedge clk) wr_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(rd_data == 8'h96 && !sdat_oe, "R7 rx-mode write ignored", rd_data, 8'h96);
    ack_flag();

    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule